// File: doc/BRIEF.md
# Kernel Regression Solver Sequencer

This block controls one evaluation of a kernel-weighted regression. A host gives it one two-channel query. The block then walks a fixed set of 100 stored reference points. For every point it sends the point index to an external kernel evaluator. The evaluator returns two terms in the same cycle: a kernel weight, and that weight multiplied by the point's stored output. The block sums both terms over all points. It then divides the weighted-output sum by the weight sum and returns the quotient to the host.

A free-running tick counter is sampled when the query is taken and again when the quotient is ready, so the host also receives the run time in cycles. The walk can be spread over 1, 2, 4 or 5 equal lanes, chosen by parameter. Each lane covers a contiguous slice of indices. Because the sums are exact integers, every lane count yields the same bits.

Top module: `kreg_seq`

## Requirements
- R1: When `start_i` is high and the block is idle, it latches `qa_i`/`qb_i` (16-bit, 4.12) onto `kqa_o`/`kqb_o`, and `busy_o` is high from the next cycle.
- R2: A `start_i` pulse while `busy_o` is high is ignored: `kqa_o`/`kqb_o` keep the first query, no extra result is produced, and the result reflects the first query only.
- R3: With NLANES lanes and SUB = 100/NLANES, `kvalid_o` is high for SUB cycles. In cycle c of that window, lane l presents index l*SUB + c on `kidx_o[l*7 +: 7]`, so each index 0..99 is visited exactly once. `ksel_o` is always 0.
- R4: The weight `kwt_i` is 16-bit unsigned, scaled by 2^15. The product `kwy_i` is 32-bit unsigned, scaled by 2^30. `result_o` = floor(sum(kwy) / sum(kwt)), a 1.15 code.
- R5: If that quotient is 32768 or more, `result_o` is saturated to 16'h7FFF.
- R6: If sum(kwt) is 0, `result_o` is 0 and `div0_o` is 1. Otherwise `div0_o` is 0.
- R7: `done_o` is a one-cycle pulse, with `busy_o` low, that comes SUB+18 clock edges after the accepting edge. `elapsed_o` then equals SUB+18, the tick difference between the two captures.
- R8: NLANES values of 1, 2, 4 and 5 give bit-identical `result_o` and `div0_o` for the same query and evaluator.
- R9: After reset, `busy_o`, `done_o`, `result_o`, `div0_o`, `elapsed_o` and `ksel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a run |
| qa_i | input | Q_W | Query channel A, 4.12 |
| qb_i | input | Q_W | Query channel B, 4.12 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | QUO_W | Quotient, 1.15 |
| div0_o | output | 1 | Weight sum was zero |
| elapsed_o | output | TICK_W | Ticks between query capture and result |
| kvalid_o | output | 1 | Indices on `kidx_o` are live |
| ksel_o | output | 1 | Input-select index, tied to 0 |
| kqa_o | output | Q_W | Latched query channel A to evaluator |
| kqb_o | output | Q_W | Latched query channel B to evaluator |
| kidx_o | output | NLANES*7 | Per-lane reference index |
| kwt_i | input | NLANES*WT_W | Per-lane kernel weight |
| kwy_i | input | NLANES*WY_W | Per-lane weight times reference output |

## Verification
Every result is due at a fixed time: SUB+18 edges after the accepting edge. That is SUB accumulate edges, one lane-sum edge, one divider-load edge, fifteen divide steps and one output edge. The driver task places the expected quotient and flag in a queue for each of the four lane counts. The monitor pops an entry only on the falling edge where that instance's `done_o` is high, and it checks `elapsed_o` against SUB+18 for that lane count. A done with an empty queue, or a queue left with entries at the end, is reported as a failure.

// File: rtl/kreg_pkg.sv
package kreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SUM,
    ST_LOAD,
    ST_DIV,
    ST_FIN
  } kreg_state_e;
endpackage

// File: rtl/kreg_tick.sv
module kreg_tick #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick_o
);
  logic [TICK_W-1:0] tick_q, tick_d;

  always_comb tick_d = tick_q + TICK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/kreg_lane_acc.sv
module kreg_lane_acc #(
  parameter int WT_W = 16,
  parameter int WY_W = 32,
  parameter int SW_W = 23,
  parameter int SY_W = 39
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [WT_W-1:0] wt_i,
  input  logic [WY_W-1:0] wy_i,
  output logic [SW_W-1:0] sw_o,
  output logic [SY_W-1:0] sy_o
);
  logic [SW_W-1:0] sw_q, sw_d;
  logic [SY_W-1:0] sy_q, sy_d;

  always_comb begin
    sw_d = sw_q;
    sy_d = sy_q;
    if (clr_i) begin
      sw_d = '0;
      sy_d = '0;
    end else if (en_i) begin
      sw_d = sw_q + SW_W'(wt_i);
      sy_d = sy_q + SY_W'(wy_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      sy_q <= '0;
    end else if (clr_i || en_i) begin
      sw_q <= sw_d;
      sy_q <= sy_d;
    end
  end

  assign sw_o = sw_q;
  assign sy_o = sy_q;
endmodule

// File: rtl/kreg_div.sv
module kreg_div #(
  parameter int NUM_W = 39,
  parameter int DEN_W = 23,
  parameter int QUO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [QUO_W-1:0] q_o,
  output logic             zero_o,
  output logic             last_o
);
  localparam int FB   = QUO_W - 1;
  localparam int WIDE = (NUM_W > DEN_W + FB) ? NUM_W : DEN_W + FB;
  localparam int RW   = WIDE + 1;
  localparam int CW   = $clog2(FB + 1);

  logic [RW-1:0] rem_q, rem_d, dsh_q, dsh_d, num_x, den_x;
  logic [FB-1:0] qb_q, qb_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sat_q, sat_d, zero_q, zero_d;
  logic          fits;

  assign num_x = {{(RW-NUM_W){1'b0}}, num_i};
  assign den_x = {{(RW-DEN_W){1'b0}}, den_i};
  assign fits  = (rem_q >= dsh_q);

  always_comb begin
    rem_d  = rem_q;
    dsh_d  = dsh_q;
    qb_d   = qb_q;
    cnt_d  = cnt_q;
    sat_d  = sat_q;
    zero_d = zero_q;
    if (load_i) begin
      rem_d  = num_x;
      dsh_d  = den_x << (FB - 1);
      qb_d   = '0;
      cnt_d  = '0;
      sat_d  = (num_x >= (den_x << FB));
      zero_d = (den_i == '0);
    end else if (step_i) begin
      if (fits) rem_d = rem_q - dsh_q;
      qb_d  = {qb_q[FB-2:0], fits};
      dsh_d = dsh_q >> 1;
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dsh_q  <= '0;
      qb_q   <= '0;
      cnt_q  <= '0;
      sat_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (load_i || step_i) begin
      rem_q  <= rem_d;
      dsh_q  <= dsh_d;
      qb_q   <= qb_d;
      cnt_q  <= cnt_d;
      sat_q  <= sat_d;
      zero_q <= zero_d;
    end
  end

  assign last_o = step_i && (cnt_q == CW'(FB - 1));
  assign zero_o = zero_q;

  always_comb begin
    if (zero_q)     q_o = '0;
    else if (sat_q) q_o = {1'b0, {FB{1'b1}}};
    else            q_o = {1'b0, qb_q};
  end
endmodule

// File: rtl/kreg_seq.sv
module kreg_seq
  import kreg_pkg::*;
#(
  parameter int NPTS   = 100,
  parameter int NLANES = 1,
  parameter int Q_W    = 16,
  parameter int WT_W   = 16,
  parameter int WY_W   = 32,
  parameter int QUO_W  = 16,
  parameter int TICK_W = 32,
  parameter int IDX_W  = $clog2(NPTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [Q_W-1:0]          qa_i,
  input  logic [Q_W-1:0]          qb_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [QUO_W-1:0]        result_o,
  output logic                    div0_o,
  output logic [TICK_W-1:0]       elapsed_o,
  output logic                    kvalid_o,
  output logic                    ksel_o,
  output logic [Q_W-1:0]          kqa_o,
  output logic [Q_W-1:0]          kqb_o,
  output logic [NLANES*IDX_W-1:0] kidx_o,
  input  logic [NLANES*WT_W-1:0]  kwt_i,
  input  logic [NLANES*WY_W-1:0]  kwy_i
);
  localparam int SUB   = NPTS / NLANES;
  localparam int CNT_W = $clog2(SUB + 1);
  localparam int EXT   = $clog2(NPTS + 1);
  localparam int SW_W  = WT_W + EXT;
  localparam int SY_W  = WY_W + EXT;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  kreg_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [Q_W-1:0]    qa_q, qb_q;
  logic [TICK_W-1:0] tick, t0_q;
  logic [SW_W-1:0]   sw_tot_q, sw_sum;
  logic [SY_W-1:0]   sy_tot_q, sy_sum;
  logic [QUO_W-1:0]  res_q, div_q;
  logic              div0_q, done_q, div_zero, div_last;
  logic [TICK_W-1:0] el_q;
  logic              accept, run_en;

  logic [SW_W-1:0] lane_sw [NLANES];
  logic [SY_W-1:0] lane_sy [NLANES];

  assign accept = (state_q == ST_IDLE) && start_i;
  assign run_en = (state_q == ST_RUN);

  kreg_tick #(.TICK_W(TICK_W)) tick_i (
    .clk(clk), .rst_n(rst_sync_n), .tick_o(tick)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    assign kidx_o[l*IDX_W +: IDX_W] = IDX_W'(l * SUB) + IDX_W'(cnt_q);

    kreg_lane_acc #(
      .WT_W(WT_W), .WY_W(WY_W), .SW_W(SW_W), .SY_W(SY_W)
    ) acc_i (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .clr_i(accept),
      .en_i (run_en),
      .wt_i (kwt_i[l*WT_W +: WT_W]),
      .wy_i (kwy_i[l*WY_W +: WY_W]),
      .sw_o (lane_sw[l]),
      .sy_o (lane_sy[l])
    );
  end

  always_comb begin
    sw_sum = '0;
    sy_sum = '0;
    for (int l = 0; l < NLANES; l++) begin
      sw_sum = sw_sum + lane_sw[l];
      sy_sum = sy_sum + lane_sy[l];
    end
  end

  kreg_div #(.NUM_W(SY_W), .DEN_W(SW_W), .QUO_W(QUO_W)) div_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load_i(state_q == ST_LOAD),
    .step_i(state_q == ST_DIV),
    .num_i (sy_tot_q),
    .den_i (sw_tot_q),
    .q_o   (div_q),
    .zero_o(div_zero),
    .last_o(div_last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(SUB - 1)) state_d = ST_SUM;
      end
      ST_SUM:  state_d = ST_LOAD;
      ST_LOAD: state_d = ST_DIV;
      ST_DIV:  if (div_last) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      qa_q <= '0;
      qb_q <= '0;
      t0_q <= '0;
    end else if (accept) begin
      qa_q <= qa_i;
      qb_q <= qb_i;
      t0_q <= tick;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sw_tot_q <= '0;
      sy_tot_q <= '0;
    end else if (state_q == ST_SUM) begin
      sw_tot_q <= sw_sum;
      sy_tot_q <= sy_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      div0_q <= 1'b0;
      el_q   <= '0;
    end else if (state_q == ST_FIN) begin
      res_q  <= div_q;
      div0_q <= div_zero;
      el_q   <= tick - t0_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= (state_q == ST_FIN);
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign result_o  = res_q;
  assign div0_o    = div0_q;
  assign elapsed_o = el_q;
  assign kvalid_o  = run_en;
  assign ksel_o    = 1'b0;
  assign kqa_o     = qa_q;
  assign kqb_o     = qb_q;
endmodule

// File: rtl/kreg_seq_chk.sv
module kreg_seq_chk #(
  parameter int Q_W   = 16,
  parameter int QUO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [QUO_W-1:0] result_o,
  input logic             div0_o,
  input logic             kvalid_o,
  input logic [Q_W-1:0]   kqa_o,
  input logic [Q_W-1:0]   kqb_o
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_hold_query_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(kqa_o) && $stable(kqb_o)));

  assert_walk_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kvalid_o |-> busy_o);

  assert_saturated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o[QUO_W-1] == 1'b0));

  assert_zero_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div0_o) |-> (result_o == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind kreg_seq kreg_seq_chk #(.Q_W(Q_W), .QUO_W(QUO_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .result_o(result_o),
  .div0_o  (div0_o),
  .kvalid_o(kvalid_o),
  .kqa_o   (kqa_o),
  .kqb_o   (kqb_o)
);

// File: tb/kreg_seq_tb_top.sv
module kreg_seq_tb_top;
  localparam int NCFG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] qa = '0, qb = '0;
  int          mode = 0;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  typedef struct {
    logic [15:0] res;
    logic        flag;
  } exp_t;

  exp_t exp_q [NCFG][$];

  logic [NCFG-1:0] done_w, busy_w, div0_w, ksel_w;
  logic [15:0]     res_w [NCFG];
  logic [31:0]     el_w  [NCFG];
  logic [15:0]     kqa_w [NCFG];

  function automatic int lanes_of(int k);
    return (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 4 : 5;
  endfunction

  function automatic logic [15:0] ev_wt(int idx, logic [15:0] a, logic [15:0] b, int m);
    case (m)
      0: return 16'((idx * 1103 + int'(a) * 7 + int'(b) * 13) & 'h7FFF);
      1: return 16'h0000;
      2: return 16'h0001;
      3: return (idx == 99) ? 16'h4000 : 16'h0000;
      4: return (idx == 0) ? 16'h2345 : 16'h0000;
      5: return 16'h7FFF;
      default: return 16'h0100;
    endcase
  endfunction

  function automatic logic [31:0] ev_wy(int idx, logic [15:0] a, logic [15:0] b, int m);
    logic [31:0] w;
    w = 32'(ev_wt(idx, a, b, m));
    case (m)
      0: return w * 32'((idx * 521 + 777 + int'(a)) & 'h7FFF);
      1: return 32'h0;
      2: return 32'h0010_0000;
      3, 4: return w * 32'h1234;
      5: return w * 32'h7FFF;
      default: return w << 15;
    endcase
  endfunction

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    localparam int NL = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 4 : 5;
    logic [NL*7-1:0]  kidx;
    logic [NL*16-1:0] kwt;
    logic [NL*32-1:0] kwy;
    logic [15:0]      kqa, kqb;
    logic             kvalid;

    kreg_seq #(.NLANES(NL)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .qa_i(qa), .qb_i(qb),
      .busy_o(busy_w[k]), .done_o(done_w[k]), .result_o(res_w[k]),
      .div0_o(div0_w[k]), .elapsed_o(el_w[k]), .kvalid_o(kvalid),
      .ksel_o(ksel_w[k]), .kqa_o(kqa), .kqb_o(kqb), .kidx_o(kidx),
      .kwt_i(kwt), .kwy_i(kwy)
    );

    assign kqa_w[k] = kqa;

    always_comb begin
      for (int l = 0; l < NL; l++) begin
        kwt[l*16 +: 16] = ev_wt(int'(kidx[l*7 +: 7]), kqa, kqb, mode);
        kwy[l*32 +: 32] = ev_wy(int'(kidx[l*7 +: 7]), kqa, kqb, mode);
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected quotient per R4/R5/R6, same for every lane count (R8)
  function automatic exp_t model(logic [15:0] a, logic [15:0] b, int m);
    longint sw = 0, sy = 0, q;
    exp_t e;
    for (int i = 0; i < 100; i++) begin
      sw += longint'(ev_wt(i, a, b, m));
      sy += longint'(ev_wy(i, a, b, m));
    end
    if (sw == 0) begin
      e.res = 16'h0; e.flag = 1'b1;
    end else begin
      q = sy / sw;
      e.res  = (q >= 32768) ? 16'h7FFF : 16'(q);
      e.flag = 1'b0;
    end
    return e;
  endfunction

  task automatic drive(logic [15:0] a, logic [15:0] b, int m);
    exp_t e;
    mode = m;
    e = model(a, b, m);
    for (int k = 0; k < NCFG; k++) exp_q[k].push_back(e);
    @(negedge clk);
    qa = a; qb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy_w == '1, "R1", "busy after accept", busy_w, 4'hF);
    check(kqa_w[0] == a, "R1", "latched query", kqa_w[0], a);
  endtask

  task automatic run(logic [15:0] a, logic [15:0] b, int m);
    drive(a, b, m);
    repeat (125) @(negedge clk);
  endtask

  // monitor: results are due SUB+18 edges after the accepting edge (R7)
  always @(negedge clk) begin
    for (int k = 0; k < NCFG; k++) begin
      if (rst_n && done_w[k]) begin
        if (exp_q[k].size() == 0) begin
          check(1'b0, "R2", "unexpected done", k, -1);
        end else begin
          exp_t e;
          e = exp_q[k].pop_front();
          check(res_w[k] == e.res, "R4", $sformatf("result lanes=%0d", lanes_of(k)), res_w[k], e.res);
          check(div0_w[k] == e.flag, "R6", "div0 flag", div0_w[k], e.flag);
          check(el_w[k] == 32'(100 / lanes_of(k) + 18), "R7", "elapsed", el_w[k], 100 / lanes_of(k) + 18);
          check(!busy_w[k], "R7", "busy with done", busy_w[k], 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(busy_w == '0, "R9", "busy", busy_w, 0);
    check(done_w == '0, "R9", "done", done_w, 0);
    check(res_w[0] == '0, "R9", "result", res_w[0], 0);
    check(div0_w == '0, "R9", "div0", div0_w, 0);
    check(el_w[0] == '0, "R9", "elapsed", el_w[0], 0);
    check(ksel_w == '0, "R9", "ksel", ksel_w, 0);

    run(16'h0800, 16'h0C00, 0);           // R4 R8 general pattern
    run(16'h1000, 16'h0000, 0);           // R4 R8 query at 1.0 / 0.0
    run(16'h0123, 16'h0FED, 0);
    run(16'h0400, 16'h0400, 1);           // R6 zero weight sum
    run(16'h0400, 16'h0400, 2);           // R5 far over range
    run(16'h0400, 16'h0400, 5);           // R5 exactly 0x7FFF, no saturation
    run(16'h0400, 16'h0400, 6);           // R5 quotient exactly 32768
    run(16'h0200, 16'h0300, 3);           // R3 only last index carries weight
    run(16'h0200, 16'h0300, 4);           // R3 only index 0 carries weight

    // R2: second start while busy is ignored
    drive(16'h0A00, 16'h0500, 0);
    repeat (20) @(negedge clk);
    check(ksel_w == '0, "R3", "ksel during run", ksel_w, 0);
    qa = 16'h0111; qb = 16'h0222; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(kqa_w[0] == 16'h0A00, "R2", "query held while busy", kqa_w[0], 16'h0A00);
    repeat (130) @(negedge clk);
    check(busy_w == '0, "R2", "no extra run started", busy_w, 0);

    for (int k = 0; k < NCFG; k++)
      check(exp_q[k].size() == 0, "R7", "results outstanding", exp_q[k].size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule